// File: doc/BRIEF.md
# Power Violation Clock Gate Supervisor

This block sits between a platform shell and user logic. It watches periodic core-supply power samples, each an unsigned watt value qualified by a one-cycle valid strobe, and tells the user logic through a 2-bit state whether it is running normally, close to the limit, or over it. The warning state lets the user logic throttle itself before the hard limit is reached.

When a sample goes above the hard limit, every clock enable feeding the user logic drops and stays low. The condition is sticky: only an image load or a clear command brings the clocks back. While gated, host requests aimed at the user logic are not forwarded. Each one completes with an error response after a fixed number of cycles, so the host never hangs. A load operation reports on completion whether a violation hit it.

Top module: `pwr_guard_top`

## Requirements
- R1: `pwr_state_o` uses 2'b00 for OK, 2'b10 for warning and 2'b11 for violation; 2'b01 is never driven. After reset the state is OK and all `clk_en_o` bits are 1.
- R2: A valid sample above WARN_W (85) and at or below VIOL_W (95) sets the state to warning from the next cycle.
- R3: With no violation latched, a valid sample at or below WARN_W returns the state to OK. A sample without `pwr_valid_i` has no effect.
- R4: A valid sample above VIOL_W sets the state to violation and drives every `clk_en_o` bit to 0 from the next cycle.
- R5: Once a violation is latched, no sample changes the state or the clock enables.
- R6: A `load_i` or `clear_i` pulse sets the state to OK and re-enables all clocks from the next cycle. It takes precedence over a sample in the same cycle.
- R7: While not gated, an accepted host request appears on `ureq_valid_o`/`ureq_data_o` in the same cycle. A user response passes to `hrsp_*` in the same cycle with `hrsp_err_o` = 0.
- R8: While gated, host requests are not forwarded. Each request completes with `hrsp_err_o` = 1 and data 0, exactly TMO_CYC cycles after the cycle it was accepted. A request already forwarded when gating starts also ends with an error response, and any user response is then dropped.
- R9: `hreq_ready_o` is low while a request is outstanding. A request is accepted only when `hreq_valid_i` and `hreq_ready_o` are both high.
- R10: `load_done_o` pulses LOAD_CYC cycles after the cycle of the `load_i` pulse. `load_fail_o` is high with that pulse exactly when a violation was latched in any cycle of the load.
- R11: `clear_i` during a load aborts it, and no `load_done_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_watts_i | input | PWR_W | Core-supply power sample in watts |
| pwr_valid_i | input | 1 | Sample strobe |
| load_i | input | 1 | Image load start pulse |
| clear_i | input | 1 | Image clear pulse |
| pwr_state_o | output | 2 | Power state to user logic |
| clk_en_o | output | NUM_CLK | Clock enables to user logic |
| load_done_o | output | 1 | Load completion pulse |
| load_fail_o | output | 1 | Load failed on power violation, valid with load_done_o |
| hreq_valid_i | input | 1 | Host request valid |
| hreq_data_i | input | DATA_W | Host request payload |
| hreq_ready_o | output | 1 | Ready for a host request |
| hrsp_valid_o | output | 1 | Host response valid |
| hrsp_data_o | output | DATA_W | Host response payload |
| hrsp_err_o | output | 1 | Host response is a timeout error |
| ureq_valid_o | output | 1 | Request to user logic |
| ureq_data_o | output | DATA_W | Request payload to user logic |
| ursp_valid_i | input | 1 | Response from user logic |
| ursp_data_i | input | DATA_W | Response payload from user logic |

## Verification
The assertions check several properties on every cycle. The reserved state code never appears, and the violation state always has every clock enable low. A latched violation survives until a command, and a command always returns the state to OK. Nothing is forwarded while gated, and an accepted request always drops ready on the next cycle. Other behaviour shows only through the bench's scenarios: the exact 85/95 W boundaries, the exact timeout and load latencies, a forwarded request overtaken by gating, failure tagging across a load, and a clear that aborts a load. The bench compares every output against its own model on every clock to cover these.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    PS_OK   = 2'b00,
    PS_RSVD = 2'b01,
    PS_WARN = 2'b10,
    PS_VIOL = 2'b11
  } pwr_state_e;
endpackage

// File: rtl/pwr_monitor.sv
module pwr_monitor
  import pwr_guard_pkg::*;
#(
  parameter int PWR_W  = 8,
  parameter int WARN_W = 85,
  parameter int VIOL_W = 95
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PWR_W-1:0] pwr_i,
  input  logic             valid_i,
  input  logic             cmd_i,
  output logic             viol_o,
  output pwr_state_e       state_o
);
  localparam logic [PWR_W-1:0] WarnLim = PWR_W'(WARN_W);
  localparam logic [PWR_W-1:0] ViolLim = PWR_W'(VIOL_W);

  logic viol_q, warn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
      warn_q <= 1'b0;
    end else if (cmd_i) begin
      viol_q <= 1'b0;
      warn_q <= 1'b0;
    end else if (valid_i && !viol_q) begin
      if (pwr_i > ViolLim) viol_q <= 1'b1;
      else                 warn_q <= (pwr_i > WarnLim);
    end
  end

  always_comb begin
    if (viol_q)      state_o = PS_VIOL;
    else if (warn_q) state_o = PS_WARN;
    else             state_o = PS_OK;
  end

  assign viol_o = viol_q;

  AST_NO_RSVD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != PS_RSVD); // R1
  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == PS_VIOL) && !cmd_i |=> state_o == PS_VIOL); // R5
  AST_CMD_TO_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> state_o == PS_OK); // R6
  AST_OVER_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (pwr_i > ViolLim) && !cmd_i |=> state_o == PS_VIOL); // R4
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int NUM_CLK = 2
) (
  input  logic               gated_i,
  output logic [NUM_CLK-1:0] clk_en_o
);
  for (genvar g = 0; g < NUM_CLK; g++) begin : g_en
    assign clk_en_o[g] = ~gated_i;
  end
endmodule

// File: rtl/txn_guard.sv
module txn_guard #(
  parameter int DATA_W  = 32,
  parameter int TMO_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gated_i,
  input  logic              hreq_valid_i,
  input  logic [DATA_W-1:0] hreq_data_i,
  output logic              hreq_ready_o,
  output logic              hrsp_valid_o,
  output logic [DATA_W-1:0] hrsp_data_o,
  output logic              hrsp_err_o,
  output logic              ureq_valid_o,
  output logic [DATA_W-1:0] ureq_data_o,
  input  logic              ursp_valid_i,
  input  logic [DATA_W-1:0] ursp_data_i
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] CntLast = CNT_W'(TMO_CYC - 1);

  logic             out_q, tmo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept, tmo_fire, usr_rsp;

  assign accept   = hreq_valid_i && !out_q;
  assign tmo_fire = tmo_q && (cnt_q == CntLast);
  assign usr_rsp  = ursp_valid_i && out_q && !tmo_q && !gated_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      tmo_q <= 1'b0;
      cnt_q <= '0;
    end else if (tmo_fire) begin
      out_q <= 1'b0;
      tmo_q <= 1'b0;
      cnt_q <= '0;
    end else if (usr_rsp) begin
      out_q <= 1'b0;
    end else if (accept) begin
      out_q <= 1'b1;
      tmo_q <= gated_i;
      cnt_q <= '0;
    end else if (out_q && !tmo_q && gated_i) begin
      // forwarded request overtaken by gating
      tmo_q <= 1'b1;
      cnt_q <= '0;
    end else if (tmo_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hreq_ready_o = !out_q;
  assign ureq_valid_o = accept && !gated_i;
  assign ureq_data_o  = hreq_data_i;
  assign hrsp_valid_o = tmo_fire || usr_rsp;
  assign hrsp_err_o   = tmo_fire;
  assign hrsp_data_o  = tmo_fire ? '0 : ursp_data_i;

  AST_NO_FWD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gated_i |-> !ureq_valid_o); // R8
  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreq_valid_i && hreq_ready_o |=> !hreq_ready_o); // R9
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrsp_valid_o && hrsp_err_o |-> hrsp_data_o == '0); // R8
endmodule

// File: rtl/load_tracker.sv
module load_tracker #(
  parameter int LOAD_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clear_i,
  input  logic viol_i,
  output logic done_o,
  output logic fail_o
);
  localparam int CNT_W = $clog2(LOAD_CYC + 1);
  localparam logic [CNT_W-1:0] CntLast = CNT_W'(LOAD_CYC - 1);

  logic             busy_q, hit_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_q && (cnt_q == CntLast);
  assign fail_o = done_o && (hit_q || viol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hit_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      busy_q <= 1'b0;
      hit_q  <= 1'b0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      hit_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done_o) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        hit_q <= hit_q | viol_i;
      end
    end
  end

  AST_CLEAR_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !done_o); // R11
endmodule

// File: rtl/pwr_guard_top.sv
module pwr_guard_top
  import pwr_guard_pkg::*;
#(
  parameter int PWR_W    = 8,
  parameter int WARN_W   = 85,
  parameter int VIOL_W   = 95,
  parameter int NUM_CLK  = 2,
  parameter int DATA_W   = 32,
  parameter int TMO_CYC  = 16,
  parameter int LOAD_CYC = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PWR_W-1:0]   pwr_watts_i,
  input  logic               pwr_valid_i,
  input  logic               load_i,
  input  logic               clear_i,
  output logic [1:0]         pwr_state_o,
  output logic [NUM_CLK-1:0] clk_en_o,
  output logic               load_done_o,
  output logic               load_fail_o,
  input  logic               hreq_valid_i,
  input  logic [DATA_W-1:0]  hreq_data_i,
  output logic               hreq_ready_o,
  output logic               hrsp_valid_o,
  output logic [DATA_W-1:0]  hrsp_data_o,
  output logic               hrsp_err_o,
  output logic               ureq_valid_o,
  output logic [DATA_W-1:0]  ureq_data_o,
  input  logic               ursp_valid_i,
  input  logic [DATA_W-1:0]  ursp_data_i
);
  logic       viol;
  pwr_state_e state;

  pwr_monitor #(.PWR_W(PWR_W), .WARN_W(WARN_W), .VIOL_W(VIOL_W)) u_mon (
    .clk_i, .rst_ni,
    .pwr_i   (pwr_watts_i),
    .valid_i (pwr_valid_i),
    .cmd_i   (load_i | clear_i),
    .viol_o  (viol),
    .state_o (state)
  );

  assign pwr_state_o = state;

  clk_gate_bank #(.NUM_CLK(NUM_CLK)) u_gate (
    .gated_i  (viol),
    .clk_en_o (clk_en_o)
  );

  txn_guard #(.DATA_W(DATA_W), .TMO_CYC(TMO_CYC)) u_txn (
    .clk_i, .rst_ni,
    .gated_i (viol),
    .hreq_valid_i, .hreq_data_i, .hreq_ready_o,
    .hrsp_valid_o, .hrsp_data_o, .hrsp_err_o,
    .ureq_valid_o, .ureq_data_o,
    .ursp_valid_i, .ursp_data_i
  );

  load_tracker #(.LOAD_CYC(LOAD_CYC)) u_load (
    .clk_i, .rst_ni,
    .load_i, .clear_i,
    .viol_i (viol),
    .done_o (load_done_o),
    .fail_o (load_fail_o)
  );

  AST_CLK_OFF_IN_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_state_o == 2'b11 |-> clk_en_o == '0); // R4
  AST_CLK_ON_ELSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_state_o != 2'b11 |-> &clk_en_o); // R6
endmodule

// File: tb/pwr_guard_top_test.sv
`timescale 1ns/1ps
module pwr_guard_top_test;
  localparam int TMO  = 16;
  localparam int LOAD = 20;
  localparam int DW   = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] pwr = '0;
  logic pv = 0, ld = 0, clr = 0, hv = 0, uv = 0;
  logic [DW-1:0] hd = '0, ud = '0;
  logic [1:0] st;
  logic [1:0] cen;
  logic ldone, lfail, hrdy, hrv, herr, urv;
  logic [DW-1:0] hrd, urd;

  int compared = 0, mismatched = 0, cycles = 0;
  bit started = 0;

  always #2 clk = ~clk;

  pwr_guard_top #(.TMO_CYC(TMO), .LOAD_CYC(LOAD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_watts_i(pwr), .pwr_valid_i(pv),
    .load_i(ld), .clear_i(clr), .pwr_state_o(st), .clk_en_o(cen),
    .load_done_o(ldone), .load_fail_o(lfail),
    .hreq_valid_i(hv), .hreq_data_i(hd), .hreq_ready_o(hrdy),
    .hrsp_valid_o(hrv), .hrsp_data_o(hrd), .hrsp_err_o(herr),
    .ureq_valid_o(urv), .ureq_data_o(urd),
    .ursp_valid_i(uv), .ursp_data_i(ud)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_viol, m_warn, m_out, m_busy, m_hit;
  int m_tmo_left, m_load_left;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_viol = 0; m_warn = 0; m_out = 0; m_busy = 0; m_hit = 0;
      m_tmo_left = 0; m_load_left = 0;
    end else begin
      bit gated, resp_t, resp_u;
      gated  = m_viol;
      resp_t = (m_tmo_left == 1);
      resp_u = uv && m_out && m_tmo_left == 0 && !gated;
      if (resp_t) begin m_out = 0; m_tmo_left = 0; end
      else if (resp_u) m_out = 0;
      else if (hv && !m_out) begin m_out = 1; m_tmo_left = gated ? TMO : 0; end
      else if (m_out && gated && m_tmo_left == 0) m_tmo_left = TMO;
      else if (m_tmo_left > 1) m_tmo_left--;
      if (clr) m_busy = 0;
      else if (ld) begin m_busy = 1; m_load_left = LOAD; m_hit = 0; end
      else if (m_busy) begin
        if (m_load_left == 1) m_busy = 0;
        else begin m_load_left--; m_hit = m_hit | gated; end
      end
      if (ld || clr) begin m_viol = 0; m_warn = 0; end
      else if (pv && !m_viol) begin
        if (pwr > 95) m_viol = 1;
        else m_warn = (pwr > 85);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && started) begin
      bit rt, ru, dn;
      rt = (m_tmo_left == 1);
      ru = uv && m_out && m_tmo_left == 0 && !m_viol;
      dn = m_busy && m_load_left == 1;
      chk("R2 state", st, m_viol ? 2'b11 : (m_warn ? 2'b10 : 2'b00));
      chk("R4 clk_en", cen, m_viol ? 2'b00 : 2'b11);
      chk("R9 ready", hrdy, !m_out);
      chk("R7 ureq_valid", urv, hv && !m_out && !m_viol);
      if (urv) chk("R7 ureq_data", urd, hd);
      chk("R8 hrsp_valid", hrv, rt || ru);
      if (hrv) begin
        chk("R8 hrsp_err", herr, rt);
        chk("R7 hrsp_data", hrd, rt ? '0 : ud);
      end
      chk("R10 load_done", ldone, dn);
      chk("R10 load_fail", lfail, dn && (m_hit || m_viol));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL R8 watchdog expired act=%0d exp<=50000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic smp(input int w, input bit v);
    pwr = 8'(w); pv = v; cyc(); pv = 0;
  endtask

  task automatic cmd_clear(); clr = 1; cyc(); clr = 0; endtask

  initial begin
    int n;
    int dones;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1; started = 1;
    cyc();
    chk("R1 reset state", st, 2'b00);
    chk("R1 reset clk_en", cen, 2'b11);

    cyc(); smp(50, 1);  chk("R3 low sample", st, 2'b00);
    smp(90, 1);         chk("R2 warn", st, 2'b10);
    smp(85, 1);         chk("R3 at 85 ok", st, 2'b00);
    smp(86, 1);         chk("R2 at 86 warn", st, 2'b10);
    smp(95, 1);         chk("R2 at 95 still warn", st, 2'b10);
    smp(200, 0);        chk("R3 no strobe ignored", st, 2'b10);
    smp(96, 1);         chk("R4 violation", st, 2'b11);
                        chk("R4 clocks off", cen, 2'b00);
    smp(10, 1);         chk("R5 sticky low sample", st, 2'b11);
    smp(90, 1);         chk("R5 sticky warn sample", st, 2'b11);
    cmd_clear();        chk("R6 clear ok", st, 2'b00);
                        chk("R6 clocks on", cen, 2'b11);
    smp(99, 1);
    clr = 1; pwr = 120; pv = 1; cyc(); clr = 0; pv = 0;
    chk("R6 clear beats sample", st, 2'b00);

    // ungated transaction
    hv = 1; hd = 32'hA5A5_0001; cyc(); hv = 0;
    chk("R9 ready low", hrdy, 1'b0);
    cyc();
    uv = 1; ud = 32'h0000_1234; #0.5;
    chk("R7 rsp valid", hrv, 1'b1);
    chk("R7 rsp err", herr, 1'b0);
    chk("R7 rsp data", hrd, 32'h1234);
    cyc(); uv = 0;
    chk("R9 ready back", hrdy, 1'b1);

    // gated request times out
    smp(130, 1);
    hv = 1; hd = 32'h0BAD_0002;
    n = 0;
    do begin cyc(); hv = 0; n++; end while (!hrv && n < 100);
    chk("R8 timeout latency", n, TMO);
    chk("R8 timeout err", herr, 1'b1);
    cyc();

    // forwarded request overtaken by gating
    cmd_clear();
    hv = 1; hd = 32'h0000_0003; cyc(); hv = 0;
    smp(150, 1);
    uv = 1; ud = 32'hFFFF; cyc(); uv = 0;
    n = 0;
    while (!hrv && n < 100) begin cyc(); n++; end
    chk("R8 overtaken err", herr, 1'b1);
    cyc();

    // load without violation
    ld = 1; n = 0;
    do begin cyc(); ld = 0; n++; end while (!ldone && n < 100);
    chk("R10 load latency", n, LOAD);
    chk("R10 load ok", lfail, 1'b0);
    cyc();

    // load hit by violation
    ld = 1; cyc(); ld = 0;
    repeat (3) cyc();
    smp(140, 1);
    n = 0;
    while (!ldone && n < 100) begin cyc(); n++; end
    chk("R10 load failed", lfail, 1'b1);
    cyc();
    chk("R5 still violated", st, 2'b11);
    ld = 1; cyc(); ld = 0;
    chk("R6 load restores", st, 2'b00);
    chk("R6 load clocks on", cen, 2'b11);

    // clear aborts a load
    repeat (5) cyc();
    cmd_clear();
    dones = 0;
    repeat (LOAD + 5) begin if (ldone) dones++; cyc(); end
    chk("R11 no done after abort", dones, 0);

    repeat (4) cyc();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule